// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers packets from the D+/D- pair of a low-speed USB link. The two line levels arrive already synchronized to the system clock. They are sampled on a sample-enable that ticks a fixed number of times per bit. A phase counter picks the centre of each bit and realigns itself on every D+ transition.

While the block is idle, a rising edge on D+ arms it. It then locks onto the alternating sync pattern, which must end in two consecutive K bits. After that it removes NRZI coding and stuffed bits and assembles bytes least-significant bit first. Each completed byte is presented on a one-cycle write strobe.

The packet ends when a single-ended zero (SE0, both lines low) is seen on two consecutive bit samples. The block then pulses a done strobe with the number of whole bytes stored. A packet that breaks the stuffing rule, overruns the byte limit or has a malformed end is reported on a drop strobe instead. The consumer discards whatever was written for that packet.

Top module: `lsrx_rx`

## Requirements
- R1: After reset, wr_stb, done_stb and drop_stb are low and done_len is zero.
- R2: From idle, a 0-to-1 edge on D+ arms the receiver. The line must then show at least one K-J alternation and finish with two consecutive K bits (K = D+ high, D- low; J = D+ low, D- high). Data decoding starts with the bit after the second K, and extra leading K-J pairs are accepted.
- R3: If FS_BITS consecutive bit samples after arming show D+ low, the receiver returns to idle without any write, done or drop strobe.
- R4: A bit equal to the previous bit's level decodes as 1, and a changed level decodes as 0. Decoded bits fill a byte starting at bit 0. After the eighth bit, wr_stb pulses for one cycle with the byte on wr_byte.
- R5: After STUFF_RUN consecutive decoded 1s, the next line bit is a stuffed 0 and is discarded. The run count starts at one at the end of sync, because the last sync bit counts as a 1.
- R6: A 1 where a stuffed bit is expected raises drop_stb for one cycle and gives no done_stb for that packet.
- R7: SE0 on two consecutive bit samples ends the packet. done_stb then pulses with done_len equal to the number of whole bytes written, and any trailing partial byte is discarded. A zero-byte packet reports 0.
- R8: Up to BUF_BYTES bytes are accepted. A packet that completes one more byte raises drop_stb, writes no further byte and gives no done_stb.
- R9: Each bit is taken at sample OVS/2 counted from the last D+ transition. A bit stretched or shortened by one sample before a D+ transition still decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample tick, OVS ticks per bit time |
| line_dp | input | 1 | Synchronized D+ level |
| line_dm | input | 1 | Synchronized D- level |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_byte | output | 8 | Completed byte |
| done_stb | output | 1 | One-cycle packet-complete strobe |
| done_len | output | LEN_W | Whole bytes in the finished packet |
| drop_stb | output | 1 | One-cycle strobe: packet discarded |

## Verification
The bench builds the receiver with OVS=4, BUF_BYTES=4 and FS_BITS=3. These small values let a five-byte packet hit the overflow rule, and a few quiet bits trigger the false-start exit. With four samples per bit, stretching or shortening a bit by one sample is a full quarter-bit of phase error, which exercises the resynchronization on D+ edges. Stuffing is exercised both across byte boundaries and right at the end of sync.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SYNC  = 2'd1,
      ST_DATA  = 2'd2,
      ST_DRAIN = 2'd3
   } rx_state_t;
endpackage

// File: rtl/lsrx_phase.sv
// Bit timing: edge detect on D+ and a sample-phase counter that
// realigns on every D+ transition and strobes at mid-bit.
module lsrx_phase #(
   parameter int OVS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en,
   input  logic dp,
   input  logic run,
   output logic trig,
   output logic bit_stb
);
   localparam int             CW   = $clog2(OVS);
   localparam logic [CW-1:0]  MID  = CW'(OVS / 2);
   localparam logic [CW-1:0]  LAST = CW'(OVS - 1);
   localparam logic [CW-1:0]  ONE  = CW'(1);

   logic          dp_q;
   logic [CW-1:0] ph;
   logic          dp_edge;

   assign dp_edge = smp_en && (dp != dp_q);
   assign trig    = smp_en && dp && !dp_q;
   assign bit_stb = smp_en && run && !dp_edge && (ph == MID);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dp_q <= 1'b0;
         ph   <= '0;
      end else if (smp_en) begin
         dp_q <= dp;
         if (dp != dp_q)
            ph <= ONE;
         else if (!run || ph == LAST)
            ph <= '0;
         else
            ph <= ph + ONE;
      end
   end
endmodule

// File: rtl/lsrx_nrzi.sv
// NRZI decode with stuffed-bit removal and stuff-violation detect.
module lsrx_nrzi #(
   parameter int RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic stb,
   input  logic level,
   output logic dbit_vld,
   output logic dbit,
   output logic stuff_err
);
   localparam int RW = $clog2(RUN + 1);

   logic          prev;
   logic [RW-1:0] ones;
   logic          same;
   logic          stuff_due;

   assign same      = (level == prev);
   assign stuff_due = (ones == RW'(RUN));
   assign dbit      = same;
   assign dbit_vld  = stb && !stuff_due;
   assign stuff_err = stb && stuff_due && same;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= 1'b1;
         ones <= '0;
      end else if (load) begin
         prev <= 1'b1;
         ones <= RW'(1);
      end else if (stb) begin
         prev <= level;
         ones <= (same && !stuff_due) ? ones + RW'(1) : '0;
      end
   end
endmodule

// File: rtl/lsrx_rx.sv
module lsrx_rx
   import lsrx_pkg::*;
#(
   parameter  int OVS       = 4,
   parameter  int BUF_BYTES = 8,
   parameter  int FS_BITS   = 3,
   parameter  int STUFF_RUN = 6,
   localparam int LEN_W     = $clog2(BUF_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_en,
   input  logic             line_dp,
   input  logic             line_dm,
   output logic             wr_stb,
   output logic [7:0]       wr_byte,
   output logic             done_stb,
   output logic [LEN_W-1:0] done_len,
   output logic             drop_stb
);
   localparam int               FW      = $clog2(FS_BITS + 1);
   localparam logic [FW-1:0]    FS_LAST = FW'(FS_BITS - 1);
   localparam logic [LEN_W-1:0] LIMIT   = LEN_W'(BUF_BYTES);

   // elaboration-time parameter checks
   if (OVS < 3) begin : g_bad_ovs
      $error("lsrx_rx: OVS must be at least 3");
   end
   if (FS_BITS < 2) begin : g_bad_fs
      $error("lsrx_rx: FS_BITS must be at least 2");
   end
   if (BUF_BYTES < 1) begin : g_bad_buf
      $error("lsrx_rx: BUF_BYTES must be at least 1");
   end
   if (STUFF_RUN < 1) begin : g_bad_run
      $error("lsrx_rx: STUFF_RUN must be at least 1");
   end

   rx_state_t        st;
   logic             trig, bstb, se0;
   logic             syn_prev, se0_seen;
   logic [FW-1:0]    zrun;
   logic [2:0]       bcnt;
   logic [7:0]       shreg;
   logic [LEN_W-1:0] nbytes;
   logic             dec_stb, dec_load, dvld, dbit, serr;

   assign se0      = !line_dp && !line_dm;
   assign dec_stb  = bstb && (st == ST_DATA) && !se0 && !se0_seen;
   assign dec_load = bstb && (st == ST_SYNC) && line_dp && syn_prev;

   lsrx_phase #(.OVS(OVS)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_en  (smp_en),
      .dp      (line_dp),
      .run     (st != ST_IDLE),
      .trig    (trig),
      .bit_stb (bstb)
   );

   lsrx_nrzi #(.RUN(STUFF_RUN)) u_nrzi (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (dec_load),
      .stb       (dec_stb),
      .level     (line_dp),
      .dbit_vld  (dvld),
      .dbit      (dbit),
      .stuff_err (serr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         syn_prev <= 1'b0;
         se0_seen <= 1'b0;
         zrun     <= '0;
         bcnt     <= '0;
         shreg    <= '0;
         nbytes   <= '0;
         wr_stb   <= 1'b0;
         wr_byte  <= '0;
         done_stb <= 1'b0;
         done_len <= '0;
         drop_stb <= 1'b0;
      end else begin
         wr_stb   <= 1'b0;
         done_stb <= 1'b0;
         drop_stb <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (trig) begin
                  st       <= ST_SYNC;
                  syn_prev <= 1'b0;
                  zrun     <= '0;
               end
            end
            ST_SYNC: begin
               if (bstb) begin
                  syn_prev <= line_dp;
                  if (line_dp) begin
                     zrun <= '0;
                     if (syn_prev) begin
                        st       <= ST_DATA;
                        bcnt     <= '0;
                        nbytes   <= '0;
                        se0_seen <= 1'b0;
                     end
                  end else if (zrun == FS_LAST) begin
                     st <= ST_IDLE;
                  end else begin
                     zrun <= zrun + FW'(1);
                  end
               end
            end
            ST_DATA: begin
               if (bstb) begin
                  if (se0) begin
                     if (se0_seen) begin
                        done_stb <= 1'b1;
                        done_len <= nbytes;
                        st       <= ST_IDLE;
                     end else begin
                        se0_seen <= 1'b1;
                     end
                  end else if (se0_seen) begin
                     drop_stb <= 1'b1;
                     st       <= ST_IDLE;
                  end else if (serr) begin
                     drop_stb <= 1'b1;
                     se0_seen <= 1'b0;
                     st       <= ST_DRAIN;
                  end else if (dvld) begin
                     shreg <= {dbit, shreg[7:1]};
                     bcnt  <= bcnt + 3'd1;
                     if (bcnt == 3'd7) begin
                        if (nbytes == LIMIT) begin
                           drop_stb <= 1'b1;
                           se0_seen <= 1'b0;
                           st       <= ST_DRAIN;
                        end else begin
                           wr_stb  <= 1'b1;
                           wr_byte <= {dbit, shreg[7:1]};
                           nbytes  <= nbytes + LEN_W'(1);
                        end
                     end
                  end
               end
            end
            ST_DRAIN: begin
               if (bstb) begin
                  if (se0)
                     se0_seen <= 1'b1;
                  else if (se0_seen)
                     st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lsrx_rx_chk.sv
module lsrx_rx_chk #(
   parameter int BUF_BYTES = 8,
   parameter int LEN_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_stb,
   input logic             done_stb,
   input logic             drop_stb,
   input logic [LEN_W-1:0] done_len,
   input logic             in_data
);
   logic [LEN_W:0] wr_run;

   always_ff @(posedge clk) begin
      if (!rst_n)
         wr_run <= '0;
      else if (done_stb || drop_stb)
         wr_run <= '0;
      else if (wr_stb)
         wr_run <= wr_run + (LEN_W + 1)'(1);
   end

   assert_len_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |-> ({1'b0, done_len} == wr_run));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_run < (LEN_W + 1)'(BUF_BYTES)));

   assert_done_drop_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_stb && drop_stb));

   assert_drop_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_stb |=> !drop_stb && !done_stb);

   assert_wr_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(in_data));
endmodule

bind lsrx_rx lsrx_rx_chk #(
   .BUF_BYTES (BUF_BYTES),
   .LEN_W     (LEN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb),
   .done_stb (done_stb),
   .drop_stb (drop_stb),
   .done_len (done_len),
   .in_data  (st == lsrx_pkg::ST_DATA)
);

// File: tb/lsrx_rx_bench.sv
`timescale 1ns/1ps
module lsrx_rx_bench;
   localparam int OVS   = 4;
   localparam int BUF   = 4;
   localparam int FSB   = 3;
   localparam int LEN_W = $clog2(BUF + 1);
   localparam int NV    = 6;
   // {3'b0, jitter, extra bits[3:0], nbytes[3:0], data[31:0]}
   localparam logic [43:0] VEC [0:NV-1] = '{
      44'h0_0_1_000000A5,
      44'h0_0_3_00100069,
      44'h0_0_2_0000FFFF,
      44'h1_0_4_01FC3F7E,
      44'h0_5_2_001F5AC3,
      44'h1_0_1_00000080
   };

   logic clk = 1'b0, rst_n = 1'b0, smp_en = 1'b0;
   logic line_dp = 1'b0, line_dm = 1'b1;
   logic             wr_stb, done_stb, drop_stb;
   logic [7:0]       wr_byte;
   logic [LEN_W-1:0] done_len;

   int total = 0, bad = 0;
   bit finished = 0;
   int nwr = 0, ndone = 0, ndrop = 0;
   logic [7:0]       wr_log [0:63];
   logic [LEN_W-1:0] last_len;
   logic [1:0]       lv [0:127];   // 0 = J, 1 = K, 2 = SE0
   int nlv;
   int b_wr, b_done, b_drop;

   always #2 clk = ~clk;

   lsrx_rx #(.OVS(OVS), .BUF_BYTES(BUF), .FS_BITS(FSB)) u_lsrx_rx (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
      .line_dp(line_dp), .line_dm(line_dm),
      .wr_stb(wr_stb), .wr_byte(wr_byte),
      .done_stb(done_stb), .done_len(done_len), .drop_stb(drop_stb)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         wr_log[nwr % 64] <= wr_byte;
         nwr <= nwr + 1;
      end
      if (done_stb) begin
         ndone    <= ndone + 1;
         last_len <= done_len;
      end
      if (drop_stb) ndrop <= ndrop + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) smp_en = 1'b1;
      @(negedge clk) smp_en = 1'b0;
   endtask

   task automatic put(input logic [1:0] v);
      lv[nlv] = v;
      nlv++;
   endtask

   task automatic encode(input logic [39:0] data, input int nbits,
                         input bit stuff_on, input int xsync);
      logic cur;
      int   ones;
      nlv = 0;
      put(2'd0); put(2'd0);
      cur = 1'b0;
      for (int i = 0; i < 8 + 2 * xsync; i++) begin
         if (i != 7 + 2 * xsync) cur = ~cur;
         put({1'b0, cur});
      end
      ones = 1;
      for (int i = 0; i < nbits; i++) begin
         if (!data[i]) cur = ~cur;
         put({1'b0, cur});
         ones = data[i] ? ones + 1 : 0;
         if (stuff_on && ones == 6) begin
            cur = ~cur;
            put({1'b0, cur});
            ones = 0;
         end
      end
      put(2'd2); put(2'd2); put(2'd0); put(2'd0); put(2'd0);
   endtask

   task automatic emit(input bit jit, input int first);
      int len;
      for (int i = 0; i < nlv; i++) begin
         len = OVS;
         if (jit && i >= first && i + 1 < nlv && ((lv[i] == 2'd1) != (lv[i+1] == 2'd1)))
            len = (i % 2 == 1) ? OVS + 1 : OVS - 1;
         line_dp = (lv[i] == 2'd1);
         line_dm = (lv[i] == 2'd0);
         repeat (len) tick();
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic mark();
      b_wr = nwr; b_done = ndone; b_drop = ndrop;
   endtask

   task automatic expect_pkt(input logic [39:0] data, input int n, input string req);
      chk(ndone - b_done == 1, {req, " done count"}, ndone - b_done, 1);
      chk(ndrop == b_drop, {req, " drop count"}, ndrop - b_drop, 0);
      chk(int'(last_len) == n, {req, " length"}, int'(last_len), n);
      chk(nwr - b_wr == n, {req, " write count"}, nwr - b_wr, n);
      for (int k = 0; k < n; k++)
         chk(wr_log[(b_wr + k) % 64] == data[8*k +: 8], {req, " byte"},
             int'(wr_log[(b_wr + k) % 64]), int'(data[8*k +: 8]));
   endtask

   initial begin
      #400000;
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [43:0] e;
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(wr_stb == 1'b0,   "R1 wr_stb", int'(wr_stb), 0);
      chk(done_stb == 1'b0, "R1 done_stb", int'(done_stb), 0);
      chk(drop_stb == 1'b0, "R1 drop_stb", int'(drop_stb), 0);
      chk(done_len == '0,   "R1 done_len", int'(done_len), 0);
      repeat (4) tick();

      // table of packets: R4 R5 R7 R9
      for (int v = 0; v < NV; v++) begin
         e = VEC[v];
         n = int'(e[35:32]);
         mark();
         encode({8'h00, e[31:0]}, 8 * n + int'(e[39:36]), 1'b1, 0);
         emit(e[40], 10);
         expect_pkt({8'h00, e[31:0]}, n, $sformatf("R4/R5/R7/R9 vec%0d", v));
      end

      // R2: longer sync with extra K-J pairs
      mark();
      encode(40'h00_0000_005C, 8, 1'b1, 2);
      emit(1'b0, 0);
      expect_pkt(40'h5C, 1, "R2 long sync");

      // R3: false start, rising edge then quiet line
      mark();
      nlv = 0;
      put(2'd0); put(2'd0); put(2'd1);
      for (int i = 0; i < 6; i++) put(2'd0);
      emit(1'b0, 0);
      chk(nwr == b_wr && ndone == b_done && ndrop == b_drop, "R3 false start quiet",
          (nwr - b_wr) + (ndone - b_done) + (ndrop - b_drop), 0);

      // R2/R3: sync that never ends in K K
      mark();
      nlv = 0;
      put(2'd0);
      for (int i = 0; i < 4; i++) begin put(2'd1); put(2'd0); end
      for (int i = 0; i < 5; i++) put(2'd0);
      emit(1'b0, 0);
      chk(nwr == b_wr && ndone == b_done && ndrop == b_drop, "R2 broken sync ignored",
          (nwr - b_wr) + (ndone - b_done) + (ndrop - b_drop), 0);
      mark();
      encode(40'h42, 8, 1'b1, 0);
      emit(1'b0, 0);
      expect_pkt(40'h42, 1, "R3 recovery");

      // R7: zero-byte packet
      mark();
      encode(40'h0, 0, 1'b1, 0);
      emit(1'b0, 0);
      chk(ndone - b_done == 1, "R7 empty done", ndone - b_done, 1);
      chk(int'(last_len) == 0, "R7 empty length", int'(last_len), 0);

      // R6: seven ones without stuffing
      mark();
      encode(40'hFF, 8, 1'b0, 0);
      emit(1'b0, 0);
      chk(ndrop - b_drop == 1, "R6 stuff error drop", ndrop - b_drop, 1);
      chk(ndone == b_done, "R6 no done", ndone - b_done, 0);
      chk(nwr == b_wr, "R6 no write", nwr - b_wr, 0);

      // R8: one byte beyond the limit
      mark();
      encode(40'h55_4433_2211, 40, 1'b1, 0);
      emit(1'b0, 0);
      chk(ndrop - b_drop == 1, "R8 overflow drop", ndrop - b_drop, 1);
      chk(ndone == b_done, "R8 no done", ndone - b_done, 0);
      chk(nwr - b_wr == BUF, "R8 writes capped", nwr - b_wr, BUF);

      // after overflow the receiver takes a new packet
      mark();
      encode(40'h00_0000_3C81, 16, 1'b1, 0);
      emit(1'b1, 10);
      expect_pkt(40'h3C81, 2, "R8 recovery");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule